// File: doc/BRIEF.md
# Two-Dimensional Strided DMA Address Generator

This block produces the word-address stream for a single DMA channel. Software-side logic loads a start word address, a line length in words, a line-to-line stride in words and a line count minus one, then pulses `start`. The block offers one address at a time on a valid/ready handshake. A downstream bus engine takes each offered address and performs the transfer.

In block mode (non-zero line length) the generator walks each line word by word. Between lines it moves the line base forward by the stride, so the gap left between lines is the stride minus the line length. After the last word of the last line it pulses `done` and returns to idle.

A line length of zero selects ring mode instead. The address climbs by one word per beat through an area of stride × (count+1) words and then returns to the start. Two halves of that area each end with an event: `half_evt` marks the end of the first half and `wrap_evt` marks the end of the second. A ring buffer of N words is normally set up with stride 1 and count N−1. A `stop` input ends either mode at once.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, `addr_valid`, `done`, `half_evt` and `wrap_evt` are all low.
- R2: A `start` pulse while idle and with `stop` low latches the configuration ports. In the next cycle `addr_valid` is high with `addr` equal to the start address. A `start` while busy is ignored, and configuration changes during a run have no effect.
- R3: The address advances only on a cycle where `addr_valid` and `addr_ready` are both high. While `addr_ready` is low, `addr` and `addr_valid` hold.
- R4: In block mode (`cfg_len` non-zero), beat n carries address start + (n div len) × stride + (n mod len). The beats run for n from 0 to len × (count+1) − 1, so a count of 0 gives one line.
- R5: In block mode, `done` is high for exactly one cycle, in the cycle after the last beat is accepted. In that same cycle `addr_valid` is already low.
- R6: With `cfg_len` equal to 0 (ring mode), beat k carries address start + (k mod A), where A = stride × (count+1). Ring mode never raises `done` and runs until stopped.
- R7: In ring mode, `half_evt` pulses for one cycle after the beat at offset H−1 is accepted, where H = stride × floor((count+1)/2). When H is 0, no half event is raised.
- R8: In ring mode, `wrap_evt` pulses for one cycle after the beat at offset A−1 is accepted, and the next offered address is the start address again.
- R9: `stop` high takes the generator to idle at the next edge. The beat offered in that cycle does not count as accepted, and no `done`, `half_evt` or `wrap_evt` pulse follows. `stop` also overrides a simultaneous `start`.
- R10: Address arithmetic wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sequence from the configuration ports (idle only) |
| stop | input | 1 | Abort the sequence and return to idle |
| cfg_base | input | AW | Start word address |
| cfg_len | input | LW | Words per line; 0 selects ring mode |
| cfg_stride | input | SW | Words between line starts |
| cfg_lines_m1 | input | CW | Number of lines minus one |
| addr_ready | input | 1 | Consumer accepts the offered address |
| addr_valid | output | 1 | An address is offered |
| addr | output | AW | Offered word address |
| done | output | 1 | One-cycle pulse after the final block-mode beat |
| half_evt | output | 1 | One-cycle pulse at the end of the first ring half |
| wrap_evt | output | 1 | One-cycle pulse at the end of the ring area |

## Verification
The hardest case to reach from the ports is a `stop` that lands on exactly the beat which would otherwise raise `wrap_evt` while `addr_ready` is high. The bench therefore runs each ring job for a computed number of beats, chosen so that the offered offset at the moment of the stop is A−1. It then checks that neither an event nor a further beat follows. Back-pressure comes from a periodic ready pattern, so the stall and advance paths both appear in every configuration of the swept line-length, stride and count ranges.

// File: rtl/dma2d_pkg.sv
// Shared types for the strided address generator.
package dma2d_pkg;
    typedef enum logic {ST_IDLE, ST_RUN} dma2d_state_e;
endpackage

// File: rtl/dma2d_step_cnt.sv
// Wrapping up-counter: counts 0..limit on each advance, then returns to 0.
// Assumes limit is stable while the counter advances.
module dma2d_step_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         at_lim
);
    assign at_lim = (cnt == limit);

    // Count register: clear has priority over advance.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (adv)    cnt <= at_lim ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/dma2d_fsm.sv
// Run/idle sequencer. Enters RUN on an accepted start. Leaves on stop or on
// the final accepted beat. Assumes fire is only high while busy.
module dma2d_fsm
    import dma2d_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    input  logic fire,
    input  logic finish,
    output logic busy,
    output logic load
);
    dma2d_state_e state_q;

    assign busy = (state_q == ST_RUN);
    assign load = (state_q == ST_IDLE) && start && !stop;

    // State register: stop wins over everything else.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (load) state_q <= ST_RUN;
                ST_RUN:  if (stop || (fire && finish)) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma2d_addr_gen.sv
// Top of the 2D strided address generator. Latches configuration on start.
// Block mode: addr = line_base + word offset, and line_base steps by stride.
// Ring mode (len == 0): the offset runs 0..A-1 and wraps, with half/wrap events.
// Assumes a non-zero stride in ring mode.
module dma2d_addr_gen #(
    parameter int AW = 16,
    parameter int LW = 8,
    parameter int SW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    input  logic [AW-1:0] cfg_base,
    input  logic [LW-1:0] cfg_len,
    input  logic [SW-1:0] cfg_stride,
    input  logic [CW-1:0] cfg_lines_m1,
    input  logic          addr_ready,
    output logic          addr_valid,
    output logic [AW-1:0] addr,
    output logic          done,
    output logic          half_evt,
    output logic          wrap_evt
);
    localparam int NW = CW + 1;
    localparam int OW = SW + NW;

    logic [AW-1:0] base_q, line_base_q;
    logic [LW-1:0] len_q;
    logic [SW-1:0] stride_q;
    logic [CW-1:0] lines_q;
    logic          loop_q;
    logic          busy, load, fire, finish, line_adv;
    logic [NW-1:0] nlines;
    logic [OW-1:0] area, half, off_lim, off_cnt;
    logic          off_last;
    logic [CW-1:0] line_cnt;
    logic          line_last;
    logic          done_q, half_q, wrap_q;

    // Derived ring geometry from the latched configuration.
    assign nlines  = NW'(lines_q) + NW'(1);
    assign area    = OW'(stride_q) * OW'(nlines);
    assign half    = OW'(stride_q) * OW'(nlines >> 1);
    assign off_lim = loop_q ? area - OW'(1) : OW'(len_q) - OW'(1);

    assign fire     = busy && addr_ready && !stop;
    assign finish   = !loop_q && off_last && line_last;
    assign line_adv = fire && !loop_q && off_last;

    dma2d_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .fire(fire), .finish(finish), .busy(busy), .load(load)
    );

    dma2d_step_cnt #(.W(OW)) u_off_cnt (
        .clk(clk), .rst_n(rst_n), .clr(load), .adv(fire),
        .limit(off_lim), .cnt(off_cnt), .at_lim(off_last)
    );

    dma2d_step_cnt #(.W(CW)) u_line_cnt (
        .clk(clk), .rst_n(rst_n), .clr(load), .adv(line_adv),
        .limit(lines_q), .cnt(line_cnt), .at_lim(line_last)
    );

    // Configuration capture on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            len_q    <= '0;
            stride_q <= '0;
            lines_q  <= '0;
            loop_q   <= 1'b0;
        end else if (load) begin
            base_q   <= cfg_base;
            len_q    <= cfg_len;
            stride_q <= cfg_stride;
            lines_q  <= cfg_lines_m1;
            loop_q   <= (cfg_len == '0);
        end
    end

    // Line base: reload on start, step by stride at each line end.
    always_ff @(posedge clk) begin
        if (!rst_n)        line_base_q <= '0;
        else if (load)     line_base_q <= cfg_base;
        else if (line_adv) line_base_q <= line_base_q + AW'(stride_q);
    end

    // Event pulses, registered one cycle after the triggering beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            half_q <= 1'b0;
            wrap_q <= 1'b0;
        end else begin
            done_q <= fire && finish;
            half_q <= fire && loop_q && (half != '0) && (off_cnt == half - OW'(1));
            wrap_q <= fire && loop_q && off_last;
        end
    end

    assign addr_valid = busy;
    assign addr       = line_base_q + AW'(off_cnt);
    assign done       = done_q;
    assign half_evt   = half_q;
    assign wrap_evt   = wrap_q;

    logic unused_ok;
    assign unused_ok = ^{line_cnt, base_q};
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
// Protocol checker for dma2d_addr_gen, attached by bind below.
module dma2d_addr_gen_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          stop,
    input logic          addr_ready,
    input logic          addr_valid,
    input logic [AW-1:0] addr,
    input logic          done,
    input logic          half_evt,
    input logic          wrap_evt
);
    a_r2_start_offers: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_valid && start && !stop) |=> addr_valid);

    a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ready && !stop) |=> (addr_valid && $stable(addr)));

    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !addr_valid);

    a_r5_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(addr_valid && addr_ready));

    a_r9_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!addr_valid && !done && !half_evt && !wrap_evt));

    a_r7_r8_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, half_evt, wrap_evt}));
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .addr_ready(addr_ready), .addr_valid(addr_valid), .addr(addr),
    .done(done), .half_evt(half_evt), .wrap_evt(wrap_evt)
);

// File: tb/dma2d_addr_gen_tb.sv
module dma2d_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, stop = 1'b0, addr_ready = 1'b0;
    logic [15:0] cfg_base = '0;
    logic [7:0]  cfg_len = '0, cfg_stride = '0, cfg_lines_m1 = '0;
    logic        addr_valid, done, half_evt, wrap_evt;
    logic [15:0] addr;
    int          checks = 0, errors = 0, cyc = 0, pat = 0;

    always #4 clk = ~clk;

    dma2d_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .cfg_base(cfg_base), .cfg_len(cfg_len), .cfg_stride(cfg_stride),
        .cfg_lines_m1(cfg_lines_m1), .addr_ready(addr_ready),
        .addr_valid(addr_valid), .addr(addr), .done(done),
        .half_evt(half_evt), .wrap_evt(wrap_evt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic next_ready();
        pat++;
        return (pat % 3) != 1;
    endfunction

    // Block-mode job: checks R4 addresses, R3 stalls, R5 done, R2 busy start ignore.
    task automatic run_block(input int base, input int len, input int stride, input int lm1);
        int total, n, exp;
        logic rdy;
        cfg_base = 16'(base); cfg_len = 8'(len); cfg_stride = 8'(stride);
        cfg_lines_m1 = 8'(lm1); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cfg_base = 16'h5A5A; cfg_len = 8'd7; cfg_stride = 8'd9; cfg_lines_m1 = 8'd5;
        total = len * (lm1 + 1);
        n = 0;
        while (n < total) begin
            exp = (base + (n / len) * stride + (n % len)) & 16'hFFFF;
            chk(addr_valid === 1'b1, "R2/R4 valid", int'(addr_valid), 1);
            chk(addr === 16'(exp), "R4 addr", int'(addr), exp);
            chk(done === 1'b0, "R5 early done", int'(done), 0);
            rdy = next_ready();
            addr_ready = rdy;
            start = (n == 1);
            @(negedge clk);
            start = 1'b0;
            if (rdy) n++;
        end
        addr_ready = 1'b0;
        chk(done === 1'b1, "R5 done pulse", int'(done), 1);
        chk(addr_valid === 1'b0, "R5 idle", int'(addr_valid), 0);
        @(negedge clk);
        chk(done === 1'b0, "R5 single pulse", int'(done), 0);
    endtask

    // Ring-mode job: checks R6 addresses, R7/R8 events, then R9 stop on the wrap beat.
    task automatic run_ring(input int base, input int stride, input int lm1);
        int area, half, beats, n, off;
        logic eh, ew, rdy;
        area = stride * (lm1 + 1);
        half = stride * ((lm1 + 1) / 2);
        beats = 2 * area + area - 1;
        cfg_base = 16'(base); cfg_len = 8'd0; cfg_stride = 8'(stride);
        cfg_lines_m1 = 8'(lm1); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0; eh = 1'b0; ew = 1'b0;
        while (n < beats) begin
            chk(half_evt === eh, "R7 half", int'(half_evt), int'(eh));
            chk(wrap_evt === ew, "R8 wrap", int'(wrap_evt), int'(ew));
            chk(done === 1'b0, "R6 no done", int'(done), 0);
            chk(addr === 16'((base + n % area) & 16'hFFFF), "R6 addr", int'(addr),
                (base + n % area) & 16'hFFFF);
            rdy = next_ready();
            addr_ready = rdy;
            @(negedge clk);
            eh = 1'b0; ew = 1'b0;
            if (rdy) begin
                off = n % area;
                eh = (half != 0) && (off == half - 1);
                ew = (off == area - 1);
                n++;
            end
        end
        chk(half_evt === eh, "R7 half", int'(half_evt), int'(eh));
        chk(wrap_evt === ew, "R8 wrap", int'(wrap_evt), int'(ew));
        addr_ready = 1'b1; stop = 1'b1;
        @(negedge clk);
        stop = 1'b0; addr_ready = 1'b0;
        chk(addr_valid === 1'b0, "R9 stop idle", int'(addr_valid), 0);
        chk(wrap_evt === 1'b0 && half_evt === 1'b0, "R9 no event",
            int'({half_evt, wrap_evt}), 0);
        @(negedge clk);
        chk(wrap_evt === 1'b0, "R9 no late event", int'(wrap_evt), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(addr_valid === 1'b0 && done === 1'b0 && half_evt === 1'b0 && wrap_evt === 1'b0,
            "R1 reset", int'({addr_valid, done, half_evt, wrap_evt}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(addr_valid === 1'b0, "R1 idle after reset", int'(addr_valid), 0);

        // R9: stop overrides start in idle.
        start = 1'b1; stop = 1'b1;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        chk(addr_valid === 1'b0, "R9 stop beats start", int'(addr_valid), 0);

        for (int len = 1; len <= 4; len++)
            for (int st = 0; st <= 5; st++)
                for (int lm = 0; lm <= 3; lm++)
                    run_block(16'h0100 + len * 64 + st * 8 + lm, len, st, lm);

        // R10: address wraps at 2^16.
        run_block(16'hFFFD, 3, 5, 2);

        for (int st = 1; st <= 3; st++)
            for (int lm = 0; lm <= 4; lm++)
                run_ring(16'h2000 + st * 32 + lm, st, lm);

        // R6/R10: ring straddling the top of the address space.
        run_ring(16'hFFFC, 1, 7);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule